// File: doc/BRIEF.md
# Descriptor-Ring Transmit Gatherer with Checksum Insertion

This block serves the transmit side of a network controller. After a kick from the host it walks a ring of 8-byte descriptors held in a local memory. Each descriptor is a status word followed by a pointer to a fragment. The block copies the fragment bytes into an internal frame buffer. When a fragment asks for it, the block keeps an Internet ones'-complement sum over the frame. At end of packet it writes the result into the frame, big-endian, at an offset chosen by the packet's first descriptor.

The finished frame leaves on a byte-wide valid/ready stream, starting at buffer byte 0. Back-pressure rule: while `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. A byte is consumed on each rising edge where both `out_valid` and `out_ready` are high. The walk pauses until the whole frame has been taken.

After handling each descriptor the block writes its status word back with the owner bit cleared and raises a one-cycle completion pulse. When it reaches a descriptor it does not own, it raises a one-cycle "all transmitted" pulse and goes idle. The memory is a plain synchronous port: read data appears on the cycle after a request.

Top module: `txd_csum_engine`

## Requirements
- R1: A descriptor sits at byte address `ring_base + 8*index`: the status word first, then the fragment pointer at +4. Status fields are: owner bit 31, start-of-packet bit 30, end-of-packet bit 29, checksum enable bit 28, stuff offset bits 27:20, checksum start offset bits 19:14, fragment length bits 12:0. Fragment byte at byte address A lies in memory word A with bits 1:0 cleared, lane `A[1:0]` (bits `8*A[1:0]+7 : 8*A[1:0]`).
- R2: A kick pulse starts a walk. The walk carries on while the current descriptor's owner bit is set. An unowned descriptor gives a one-cycle `all_done` pulse and ends the walk. `pending` is high from the kick until the walk ends.
- R3: The ring holds `(ring_size+1)*16` entries. `ring_index` advances by one after each descriptor and wraps from the last entry to 0.
- R4: The frame buffer holds `FB_BYTES` bytes. A fragment that would pass the end is cut to the space that remains.
- R5: Only a start-of-packet descriptor latches the start and stuff offsets, clears the running sum and restarts the frame at byte 0. The offset fields of other descriptors are ignored.
- R6: For a checksum-enabled fragment, a byte is added to the sum only when its frame position is at or after the start offset. A byte at an even position is the high byte of a 16-bit word and a byte at an odd position is the low byte, so an odd trailing byte is zero-padded.
- R7: At end of packet with checksum enable set, the complement of the folded 16-bit sum is written at the stuff offset, high byte first, then low byte at stuff+1. Each of the two bytes is written only if its position lies inside the buffer. With checksum enable clear, the frame bytes pass unchanged.
- R8: At end of packet the frame (buffer bytes 0 to length-1) is streamed only if `tx_enable` is high. `out_last` marks the final byte, and the stream follows the back-pressure rule.
- R9: Each handled descriptor's status word is written back unchanged except for the owner bit, which is cleared. A one-cycle `desc_done` pulse follows each write-back.
- R10: After reset the block is idle: `ring_index` is 0, and `pending`, `out_valid`, `mem_req`, `desc_done` and `all_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick | input | 1 | One-cycle pulse that starts a ring walk |
| ring_base | input | AW | Byte address of ring entry 0 (8-byte aligned) |
| ring_size | input | RSZ_W | Ring length code; entries = (code+1)*16 |
| tx_enable | input | 1 | Frames are streamed out only when high |
| pending | output | 1 | Kick accepted, walk not yet finished |
| ring_index | output | RSZ_W+4 | Current descriptor index |
| desc_done | output | 1 | One-cycle pulse per written-back descriptor |
| all_done | output | 1 | One-cycle pulse when an unowned descriptor is reached |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block with `FB_BYTES = 64` and `RSZ_W = 2`. The small buffer lets two 40-byte fragments reach truncation, and lets stuff offsets fall on, straddle, and lie past the buffer end. With a 16-entry ring, wrap occurs many times during the run; the bench then switches the size code to 1 and walks the index to 31 and back to 0. Sweeps run over every fragment length from 1 to 20 and every start offset from 0 to 15 across a three-fragment packet, which covers both parities of start, stuff and trailing byte. Throughout, a pseudo-random sink stalls the stream.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_WT_STAT, S_RD_PTR, S_WT_PTR, S_RD_BYTE,
    S_WT_BYTE, S_END, S_STUFF_HI, S_STUFF_LO, S_EMIT, S_WB
  } txd_state_e;

  localparam int OWN_BIT  = 31;
  localparam int SOP_BIT  = 30;
  localparam int EOP_BIT  = 29;
  localparam int CSEN_BIT = 28;

  function automatic logic [7:0] fld_stuff(input logic [31:0] s);
    return s[27:20];
  endfunction

  function automatic logic [5:0] fld_start(input logic [31:0] s);
    return s[19:14];
  endfunction

  function automatic logic [12:0] fld_len(input logic [31:0] s);
    return s[12:0];
  endfunction

  // Fold a wide ones'-complement accumulator to 16 bits and invert.
  function automatic logic [15:0] fold_inv(input logic [31:0] a);
    logic [16:0] t;
    logic [16:0] u;
    t = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    u = {1'b0, t[15:0]} + {16'b0, t[16]};
    return ~u[15:0];
  endfunction

endpackage

// File: rtl/txd_csum_acc.sv
module txd_csum_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        add_en,
  input  logic        odd_pos,
  input  logic [7:0]  byte_in,
  output logic [15:0] csum
);
  import txd_pkg::*;

  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (add_en)  acc_q <= acc_q + (odd_pos ? {24'b0, byte_in} : {16'b0, byte_in, 8'b0});
  end

  assign csum = fold_inv(acc_q);

  AST_CLEAR_EMPTY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (csum == 16'hFFFF)); // R5

endmodule

// File: rtl/txd_ring_index.sv
module txd_ring_index #(
  parameter int RSZ_W = 4,
  localparam int IW   = RSZ_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [RSZ_W-1:0] ring_size,
  output logic [IW-1:0]    idx
);
  logic [IW:0] ring_n;
  logic [IW:0] nxt;

  assign ring_n = {({1'b0, ring_size} + 1'b1), 4'b0000};
  assign nxt    = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= (nxt >= ring_n) ? '0 : nxt[IW-1:0];
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ({1'b0, idx} == ring_n - 1'b1)) |=> (idx == '0)); // R3

endmodule

// File: rtl/txd_frame_store.sv
module txd_frame_store #(
  parameter int FB_BYTES = 2048,
  localparam int PW      = $clog2(FB_BYTES + 1),
  localparam int BW      = $clog2(FB_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          emit_start,
  input  logic [PW-1:0] emit_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          busy
);
  logic [7:0]    buf_q [FB_BYTES];
  logic [PW-1:0] eidx_q;
  logic [PW-1:0] elen_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      eidx_q <= '0;
      elen_q <= '0;
    end else if (emit_start) begin
      busy   <= 1'b1;
      eidx_q <= '0;
      elen_q <= emit_len;
    end else if (busy && out_ready) begin
      if (out_last) busy <= 1'b0;
      else          eidx_q <= eidx_q + 1'b1;
    end
  end

  assign out_valid = busy;
  assign out_data  = buf_q[eidx_q[BW-1:0]];
  assign out_last  = busy && (eidx_q == elen_q - 1'b1);

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid); // R8

endmodule

// File: rtl/txd_csum_engine.sv
module txd_csum_engine #(
  parameter int AW       = 32,
  parameter int RSZ_W    = 4,
  parameter int FB_BYTES = 2048,
  localparam int IW      = RSZ_W + 4,
  localparam int PW      = $clog2(FB_BYTES + 1),
  localparam int BW      = $clog2(FB_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [AW-1:0]    ring_base,
  input  logic [RSZ_W-1:0] ring_size,
  input  logic             tx_enable,
  output logic             pending,
  output logic [IW-1:0]    ring_index,
  output logic             desc_done,
  output logic             all_done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  import txd_pkg::*;

  localparam logic [31:0] FB_L = 32'(FB_BYTES);

  txd_state_e    state_q;
  logic [31:0]   stat_q;
  logic [AW-1:0] ptr_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] cnt_q;
  logic [5:0]    start_q;
  logic [7:0]    stuff_q;

  // Derived values
  logic [AW-1:0] desc_addr;
  logic [PW-1:0] room;
  logic [13:0]   frag_len14;
  logic [13:0]   room14;
  logic [PW-1:0] eff_len;
  logic [7:0]    lane_byte;
  logic [31:0]   stuff_ext;
  logic [31:0]   stuff_ext1;
  logic [31:0]   pos_ext;
  logic          go_emit;
  logic          advance;
  logic          emit_start;
  logic          emit_busy;
  logic          sum_clear;
  logic          sum_add;
  logic [15:0]   csum;
  logic          fs_wr_en;
  logic [BW-1:0] fs_wr_addr;
  logic [7:0]    fs_wr_data;
  logic [31:0]   rd_stat;

  assign desc_addr  = ring_base + {{(AW-IW-3){1'b0}}, ring_index, 3'b000};
  assign room       = PW'(FB_BYTES) - pos_q;
  assign frag_len14 = {1'b0, fld_len(stat_q)};
  assign room14     = 14'(room);
  assign eff_len    = (frag_len14 > room14) ? room : PW'(frag_len14);
  assign lane_byte  = mem_rdata[{ptr_q[1:0], 3'b000} +: 8];
  assign stuff_ext  = {24'b0, stuff_q};
  assign stuff_ext1 = stuff_ext + 32'd1;
  assign pos_ext    = 32'(pos_q);
  assign go_emit    = tx_enable && (pos_q != '0);
  assign rd_stat    = mem_rdata;

  // Memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = stat_q;
    mem_wdata[OWN_BIT] = 1'b0;
    unique case (state_q)
      S_RD_STAT: mem_req = 1'b1;
      S_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
      end
      S_RD_BYTE: begin
        mem_req  = 1'b1;
        mem_addr = {ptr_q[AW-1:2], 2'b00};
      end
      S_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  // Frame buffer write port
  always_comb begin
    fs_wr_en   = 1'b0;
    fs_wr_addr = pos_q[BW-1:0];
    fs_wr_data = lane_byte;
    unique case (state_q)
      S_WT_BYTE: fs_wr_en = 1'b1;
      S_STUFF_HI: begin
        fs_wr_en   = (stuff_ext < FB_L);
        fs_wr_addr = stuff_ext[BW-1:0];
        fs_wr_data = csum[15:8];
      end
      S_STUFF_LO: begin
        fs_wr_en   = (stuff_ext1 < FB_L);
        fs_wr_addr = stuff_ext1[BW-1:0];
        fs_wr_data = csum[7:0];
      end
      default: ;
    endcase
  end

  assign sum_clear  = (state_q == S_WT_STAT) && rd_stat[OWN_BIT] && rd_stat[SOP_BIT];
  assign sum_add    = (state_q == S_WT_BYTE) && stat_q[CSEN_BIT] &&
                      (pos_ext >= {26'b0, start_q});
  assign advance    = (state_q == S_WB);
  assign emit_start = go_emit &&
                      (((state_q == S_END) && stat_q[EOP_BIT] && !stat_q[CSEN_BIT]) ||
                       (state_q == S_STUFF_LO));

  // Walk control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      stat_q    <= '0;
      ptr_q     <= '0;
      pos_q     <= '0;
      cnt_q     <= '0;
      start_q   <= '0;
      stuff_q   <= '0;
      pending   <= 1'b0;
      desc_done <= 1'b0;
      all_done  <= 1'b0;
    end else begin
      desc_done <= 1'b0;
      all_done  <= 1'b0;
      if (kick) pending <= 1'b1;
      unique case (state_q)
        S_IDLE: if (pending) state_q <= S_RD_STAT;
        S_RD_STAT: state_q <= S_WT_STAT;
        S_WT_STAT: begin
          stat_q <= rd_stat;
          if (!rd_stat[OWN_BIT]) begin
            all_done <= 1'b1;
            pending  <= 1'b0;
            state_q  <= S_IDLE;
          end else begin
            if (rd_stat[SOP_BIT]) begin
              start_q <= fld_start(rd_stat);
              stuff_q <= fld_stuff(rd_stat);
              pos_q   <= '0;
            end
            state_q <= S_RD_PTR;
          end
        end
        S_RD_PTR: state_q <= S_WT_PTR;
        S_WT_PTR: begin
          ptr_q   <= mem_rdata[AW-1:0];
          cnt_q   <= eff_len;
          state_q <= (eff_len == '0) ? S_END : S_RD_BYTE;
        end
        S_RD_BYTE: state_q <= S_WT_BYTE;
        S_WT_BYTE: begin
          pos_q   <= pos_q + 1'b1;
          ptr_q   <= ptr_q + 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == PW'(1)) ? S_END : S_RD_BYTE;
        end
        S_END: begin
          if (!stat_q[EOP_BIT])       state_q <= S_WB;
          else if (stat_q[CSEN_BIT])  state_q <= S_STUFF_HI;
          else if (go_emit)           state_q <= S_EMIT;
          else                        state_q <= S_WB;
        end
        S_STUFF_HI: state_q <= S_STUFF_LO;
        S_STUFF_LO: state_q <= go_emit ? S_EMIT : S_WB;
        S_EMIT: if (!emit_busy) state_q <= S_WB;
        S_WB: begin
          desc_done <= 1'b1;
          if (stat_q[EOP_BIT]) pos_q <= '0;
          state_q <= S_RD_STAT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  txd_ring_index #(.RSZ_W(RSZ_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .ring_size (ring_size),
    .idx       (ring_index)
  );

  txd_csum_acc u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (sum_clear),
    .add_en  (sum_add),
    .odd_pos (pos_q[0]),
    .byte_in (lane_byte),
    .csum    (csum)
  );

  txd_frame_store #(.FB_BYTES(FB_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (fs_wr_en),
    .wr_addr    (fs_wr_addr),
    .wr_data    (fs_wr_data),
    .emit_start (emit_start),
    .emit_len   (pos_q),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .busy       (emit_busy)
  );

  AST_WB_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]); // R9
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pos_q) <= FB_L)); // R4
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_done, all_done})); // R2
  AST_KICK_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && pending) |=> mem_req); // R2
  AST_NO_STREAM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(tx_enable)); // R8

endmodule

// File: tb/test_txd_csum_engine.sv
module test_txd_csum_engine;

  localparam int AW = 32;
  localparam int RSZ_W = 2;
  localparam int FB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [RSZ_W-1:0] ring_size = '0;
  logic tx_enable = 1'b1;
  logic pending;
  logic [RSZ_W+3:0] ring_index;
  logic desc_done, all_done;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic out_valid, out_data_last;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  txd_csum_engine #(.AW(AW), .RSZ_W(RSZ_W), .FB_BYTES(FB)) i_txd_csum_engine (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(ring_base),
    .ring_size(ring_size), .tx_enable(tx_enable), .pending(pending),
    .ring_index(ring_index), .desc_done(desc_done), .all_done(all_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_data_last)
  );

  // Memory model with a host write port
  logic [31:0] mem [0:1023];
  logic hw_en = 1'b0;
  logic [11:0] hw_addr = '0;
  logic [31:0] hw_data = '0;

  always @(posedge clk) begin
    if (hw_en) mem[hw_addr[11:2]] <= hw_data;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  // Sink with pseudo-random stalls
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= lfsr[0] | lfsr[3];
  end

  // Monitor (monotonic counters)
  logic [7:0] cap [0:8191];
  logic cap_l [0:8191];
  int cap_n = 0, dd_n = 0, ad_n = 0;
  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      cap[cap_n] = out_data;
      cap_l[cap_n] = out_data_last;
      cap_n++;
    end
    if (desc_done) dd_n++;
    if (all_done) ad_n++;
  end

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run hung (act=%0d exp<%0d cycles)", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = 12'(a); hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 7) ^ (a >> 3) ^ 8'h5A);
  endfunction

  int exp_idx = 0;
  int pk = 0;
  logic [7:0] exp_b [0:63];

  task automatic run_pkt(input int nf, input int l0, input int l1, input int l2,
                         input bit cs, input int st, input int sf, input bit txen,
                         input string rq);
    int lens[3];
    int ptrs[3];
    logic [31:0] sw[3];
    int ring_n, pos, s, elen, cb, db, ab, first_bad, di;
    logic [15:0] c;
    bit ok;
    lens[0] = l0; lens[1] = l1; lens[2] = l2;
    ring_n = (int'(ring_size) + 1) * 16;
    @(negedge clk);
    tx_enable = txen;
    for (int i = 0; i < nf; i++) begin
      ptrs[i] = 'h400 + ((pk * 53 + i * 97) % 'hB00);
      sw[i] = 32'h8000_0000 | (i == 0 ? 32'h4000_0000 : 32'h0) |
              (i == nf - 1 ? 32'h2000_0000 : 32'h0) | (cs ? 32'h1000_0000 : 32'h0) |
              (i == 0 ? (32'(sf & 255) << 20) | (32'(st & 63) << 14)
                      : (32'((sf + 77) & 255) << 20) | (32'((st + 21) & 63) << 14)) |
              32'(lens[i] & 'h1FFF);
      di = (exp_idx + i) % ring_n;
      host_wr(di * 8, sw[i]);
      host_wr(di * 8 + 4, 32'(ptrs[i]));
    end
    host_wr(((exp_idx + nf) % ring_n) * 8, 32'h0);
    // expected frame
    pos = 0;
    for (int i = 0; i < nf; i++)
      for (int j = 0; j < lens[i]; j++)
        if (pos < FB) begin exp_b[pos] = byte_at(ptrs[i] + j); pos++; end
    if (cs) begin
      s = 0;
      for (int p = st; p < pos; p++) s += (p % 2 == 0) ? (int'(exp_b[p]) << 8) : int'(exp_b[p]);
      while ((s >> 16) != 0) s = (s & 'hFFFF) + (s >> 16);
      c = ~16'(s);
      if (sf < FB) exp_b[sf] = c[15:8];
      if (sf + 1 < FB) exp_b[sf + 1] = c[7:0];
    end
    elen = (txen && pos > 0) ? pos : 0;
    cb = cap_n; db = dd_n; ab = ad_n;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    while (ad_n == ab) @(negedge clk);
    @(negedge clk);
    chk(cap_n - cb == elen, rq, "R8 emitted byte count", cap_n - cb, elen);
    ok = 1'b1; first_bad = -1;
    for (int k = 0; k < elen && k < cap_n - cb; k++)
      if (cap[cb + k] !== exp_b[k] || cap_l[cb + k] !== (k == elen - 1)) begin
        if (ok) first_bad = k;
        ok = 1'b0;
      end
    chk(ok, rq, "R6/R7 frame content+last, index of first mismatch", first_bad, -1);
    chk(dd_n - db == nf, "R9", "desc_done pulses", dd_n - db, nf);
    chk(ad_n - ab == 1, "R2", "all_done pulses", ad_n - ab, 1);
    chk(pending == 1'b0, "R2", "pending after walk", int'(pending), 0);
    for (int i = 0; i < nf; i++) begin
      di = (exp_idx + i) % ring_n;
      chk(mem[di * 2] == (sw[i] & 32'h7FFF_FFFF), "R9", "written-back status",
          int'(mem[di * 2]), int'(sw[i] & 32'h7FFF_FFFF));
    end
    exp_idx = (exp_idx + nf) % ring_n;
    chk(int'(ring_index) == exp_idx, "R3", "ring index", int'(ring_index), exp_idx);
    pk++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ring_index == '0, "R10", "ring index", int'(ring_index), 0);
    chk(!pending && !out_valid && !mem_req && !desc_done && !all_done, "R10",
        "idle outputs", int'({pending, out_valid, mem_req, desc_done, all_done}), 0);
    rst_n = 1'b1;
    for (int w = 'h100; w < 'h400; w++)
      host_wr(w * 4, {byte_at(w * 4 + 3), byte_at(w * 4 + 2), byte_at(w * 4 + 1), byte_at(w * 4)});
    // R6/R7: single fragment, every length 1..20, stuff offsets of both parities (wraps ring: R3)
    for (int l = 1; l <= 20; l++) run_pkt(1, l, 0, 0, 1'b1, 0, (l >= 2) ? l - 2 : 0, 1'b1, "R6");
    // R5/R6: three fragments, start offset sweep straddling fragment edges
    for (int st = 0; st < 16; st++) run_pkt(3, 5, 6, 7, 1'b1, st, 16, 1'b1, "R5");
    // R7: checksum disabled, frame untouched
    run_pkt(2, 9, 4, 0, 1'b0, 0, 2, 1'b1, "R7");
    // R8: transmit disabled, nothing streamed, write-back still done
    run_pkt(2, 7, 8, 0, 1'b1, 0, 3, 1'b0, "R8");
    // R4: truncation at buffer end, stuff at end, straddling end, past end
    run_pkt(2, 40, 40, 0, 1'b1, 3, 62, 1'b1, "R4");
    run_pkt(2, 40, 40, 0, 1'b1, 5, 63, 1'b1, "R4");
    run_pkt(3, 30, 30, 30, 1'b1, 0, 200, 1'b1, "R4");
    // R1: zero-length middle fragment and odd pointer lanes
    run_pkt(3, 3, 0, 4, 1'b1, 1, 0, 1'b1, "R1");
    // R3: 32-entry ring, walk index to 31 and wrap to 0
    @(negedge clk); ring_size = 2'd1;
    while (exp_idx != 31) run_pkt(1, 2, 0, 0, 1'b1, 0, 0, 1'b1, "R3");
    run_pkt(1, 3, 0, 0, 1'b1, 0, 1, 1'b1, "R3");
    chk(int'(ring_index) == 0, "R3", "wrap from 31 to 0", int'(ring_index), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule